// File: doc/BRIEF.md
# Execute-Stage Squash and Redirect Generator

This block closes the execute stage of a multithreaded out-of-order core. Every cycle it inspects, for each hardware thread, three possible squash causes: a resolved branch whose prediction turned out wrong, a memory ordering violation reported by the load/store side, and a load that could not proceed because memory was blocked. For each thread it chooses at most one cause and builds a registered squash bundle for the commit stage. The bundle carries the sequence number to squash from, the PC and next-PC at which fetch resumes, the mispredicted branch address, whether the squashing instruction itself is discarded, and the branch mispredict and taken flags.

Each cause has its own restart point. A mispredicted branch resumes at its resolved next-PC. An ordering violation resumes after the offending instruction. A blocked load resumes at the load itself, so that it executes again. A compile-time switch selects between an architecture with branch delay slots, where the taken direction is rebuilt from the PC, next-PC and next-next-PC chain and the next-next-PC is forwarded, and one without delay slots. Two wrapping counters record mispredictions, split by the direction the predictor chose.

Top module: `exec_squash_gen`

## Requirements
- R1: A mispredicted branch on a thread produces, one cycle later, a bundle with valid=1, mispredict=1, include=0, the branch's sequence number and its PC on the mispredicted-PC output.
- R2: With delay slots enabled, a mispredict restarts fetch at the branch's next-PC, and the restart next-PC output carries the branch's next-next-PC.
- R3: With delay slots enabled, taken=0 only when next-next-PC equals next-PC plus INST_BYTES and next-PC equals PC plus INST_BYTES or PC plus twice INST_BYTES. In every other case taken=1.
- R4: Without delay slots, taken=1 exactly when next-PC differs from PC plus INST_BYTES. Fetch restarts at next-PC, and the restart next-PC output is always zero.
- R5: An ordering violation produces a bundle with the offending instruction's sequence number, restart PC equal to its next-PC, include=0, and mispredict=0 and taken=0.
- R6: A blocked load produces a bundle with the load's sequence number, restart PC equal to the load's own PC and include=1. The acknowledge for that thread is high for exactly that one cycle.
- R7: On one thread, a mispredict takes priority over an ordering violation, which takes priority over a blocked load. A blocked load that loses is not acknowledged.
- R8: Each mispredict increments the predicted-taken counter when the prediction was taken, and otherwise the predicted-not-taken counter. Simultaneous mispredicts on several threads add together in the same cycle.
- R9: A bundle is valid for exactly one cycle per event. Threads are handled independently in the same cycle.
- R10: After synchronous active-low reset, all valid and acknowledge outputs, all bundle fields and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_mispred | input | NUM_THREADS | Resolved branch was mispredicted, per thread |
| br_pred_taken | input | NUM_THREADS | Predictor had chosen taken for that branch |
| br_seq | input | NUM_THREADS x 32 | Branch sequence number |
| br_pc | input | NUM_THREADS x 32 | Branch PC |
| br_npc | input | NUM_THREADS x 32 | Branch resolved next-PC |
| br_nnpc | input | NUM_THREADS x 32 | Branch resolved next-next-PC |
| ord_viol | input | NUM_THREADS | Ordering violation detected |
| ord_seq | input | NUM_THREADS x 32 | Violating instruction sequence number |
| ord_npc | input | NUM_THREADS x 32 | Violating instruction next-PC |
| ord_nnpc | input | NUM_THREADS x 32 | Violating instruction next-next-PC |
| blk_valid | input | NUM_THREADS | Load blocked by memory |
| blk_seq | input | NUM_THREADS x 32 | Blocked load sequence number |
| blk_pc | input | NUM_THREADS x 32 | Blocked load PC |
| blk_nnpc | input | NUM_THREADS x 32 | Blocked load next-next-PC |
| sq_valid | output | NUM_THREADS | Squash bundle valid |
| sq_seq | output | NUM_THREADS x 32 | Sequence number to squash from |
| sq_pc | output | NUM_THREADS x 32 | Restart fetch PC |
| sq_npc | output | NUM_THREADS x 32 | Restart fetch next-PC (zero without delay slots) |
| sq_mispc | output | NUM_THREADS x 32 | PC of mispredicted branch |
| sq_include | output | NUM_THREADS | Squashing instruction is discarded as well |
| sq_mispredict | output | NUM_THREADS | Bundle comes from a branch mispredict |
| sq_taken | output | NUM_THREADS | Recomputed branch direction |
| blk_ack | output | NUM_THREADS | Blocked load was handled |
| cnt_taken_bad | output | CNT_W | Mispredicts where taken was predicted |
| cnt_ntaken_bad | output | CNT_W | Mispredicts where not-taken was predicted |

## Verification
The hardest case is a thread that raises all three causes in the same cycle. Only the winner may show up in the bundle, and the losing blocked load must get no acknowledge. The stimulus raises all three causes together on one thread, and the violation and blocked load together on the other. A second hard case is two threads mispredicting in one cycle, which must move a counter by two. It is driven directly, and the delay-slot and plain variants run side by side on identical inputs so that the two taken rules can be compared.

// File: rtl/sqgen_pkg.sv
// Shared types for the execute-stage squash generator.
// Assumes 32-bit PCs and sequence numbers throughout the core.
package sqgen_pkg;
    localparam int ADDR_W = 32;
    localparam int SEQ_W  = 32;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [SEQ_W-1:0]  seq_t;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_BRANCH = 2'd1,
        CAUSE_ORDER  = 2'd2,
        CAUSE_BLOCK  = 2'd3
    } cause_e;

    typedef struct packed {
        logic  valid;
        seq_t  seq;
        addr_t restart_pc;
        addr_t restart_npc;
        addr_t mispc;
        logic  include_self;
        logic  mispredict;
        logic  taken;
    } bundle_t;
endpackage

// File: rtl/sqgen_taken_calc.sv
// Recomputes the direction of a resolved branch from its PC chain.
// Delay-slot variant: not taken only for a sequential NNPC with NPC at
// PC+S or PC+2S. Plain variant: taken whenever NPC is not PC+S.
// Purely combinational; assumes S = INST_BYTES is the fixed instruction size.
module sqgen_taken_calc
    import sqgen_pkg::*;
#(
    parameter int INST_BYTES = 4,
    parameter bit DELAY_SLOT = 1'b1
) (
    input  addr_t pc,
    input  addr_t npc,
    input  addr_t nnpc,
    output logic  taken
);
    localparam addr_t STEP1 = addr_t'(INST_BYTES);
    localparam addr_t STEP2 = addr_t'(2 * INST_BYTES);

    generate
        if (DELAY_SLOT) begin : g_ds
            logic seq_tail;
            logic near_npc;
            // Decide direction from the three-address chain.
            always_comb begin
                seq_tail = (nnpc == npc + STEP1);
                near_npc = (npc == pc + STEP1) || (npc == pc + STEP2);
                taken    = !(seq_tail && near_npc);
            end
        end else begin : g_plain
            logic unused_nnpc;
            // Decide direction from NPC alone.
            always_comb begin
                unused_nnpc = ^nnpc;
                taken       = (npc != pc + STEP1);
            end
        end
    endgenerate
endmodule

// File: rtl/sqgen_thread_sel.sv
// Per-thread cause arbitration and bundle assembly.
// Priority: branch mispredict, then ordering violation, then blocked load.
// Combinational; the parent registers the result.
module sqgen_thread_sel
    import sqgen_pkg::*;
#(
    parameter bit DELAY_SLOT = 1'b1
) (
    input  logic    br_mispred,
    input  logic    br_taken,
    input  seq_t    br_seq,
    input  addr_t   br_pc,
    input  addr_t   br_npc,
    input  addr_t   br_nnpc,
    input  logic    ord_viol,
    input  seq_t    ord_seq,
    input  addr_t   ord_npc,
    input  addr_t   ord_nnpc,
    input  logic    blk_valid,
    input  seq_t    blk_seq,
    input  addr_t   blk_pc,
    input  addr_t   blk_nnpc,
    output bundle_t nxt,
    output logic    blk_take
);
    cause_e cause;

    // Pick the single cause that redirects this thread this cycle.
    always_comb begin
        if (br_mispred)     cause = CAUSE_BRANCH;
        else if (ord_viol)  cause = CAUSE_ORDER;
        else if (blk_valid) cause = CAUSE_BLOCK;
        else                cause = CAUSE_NONE;
    end

    // Assemble the bundle fields for the chosen cause.
    always_comb begin
        nxt      = '0;
        blk_take = 1'b0;
        case (cause)
            CAUSE_BRANCH: begin
                nxt.valid        = 1'b1;
                nxt.seq          = br_seq;
                nxt.restart_pc   = br_npc;
                nxt.restart_npc  = DELAY_SLOT ? br_nnpc : '0;
                nxt.mispc        = br_pc;
                nxt.include_self = 1'b0;
                nxt.mispredict   = 1'b1;
                nxt.taken        = br_taken;
            end
            CAUSE_ORDER: begin
                nxt.valid        = 1'b1;
                nxt.seq          = ord_seq;
                nxt.restart_pc   = ord_npc;
                nxt.restart_npc  = DELAY_SLOT ? ord_nnpc : '0;
                nxt.include_self = 1'b0;
            end
            CAUSE_BLOCK: begin
                nxt.valid        = 1'b1;
                nxt.seq          = blk_seq;
                nxt.restart_pc   = blk_pc;
                nxt.restart_npc  = DELAY_SLOT ? blk_nnpc : '0;
                nxt.include_self = 1'b1;
                blk_take         = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sqgen_mispred_ctr.sv
// Two wrapping misprediction counters, split by predicted direction.
// Adds every thread's mispredict in the same cycle; sync active-low reset.
module sqgen_mispred_ctr #(
    parameter int NUM_THREADS = 2,
    parameter int CNT_W       = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] mis_vec,
    input  logic [NUM_THREADS-1:0] pred_taken_vec,
    output logic [CNT_W-1:0]       cnt_taken,
    output logic [CNT_W-1:0]       cnt_ntaken
);
    logic [CNT_W-1:0] inc_t;
    logic [CNT_W-1:0] inc_n;
    logic             armed;

    // Count this cycle's mispredicts per predicted direction.
    always_comb begin
        inc_t = '0;
        inc_n = '0;
        for (int i = 0; i < NUM_THREADS; i++) begin
            if (mis_vec[i] && pred_taken_vec[i])  inc_t = inc_t + CNT_W'(1);
            if (mis_vec[i] && !pred_taken_vec[i]) inc_n = inc_n + CNT_W'(1);
        end
    end

    // Accumulate the per-cycle increments.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_taken  <= '0;
            cnt_ntaken <= '0;
            armed      <= 1'b0;
        end else begin
            cnt_taken  <= cnt_taken + inc_t;
            cnt_ntaken <= cnt_ntaken + inc_n;
            armed      <= 1'b1;
        end
    end

    // R8: a counter never moves further than the thread count in one cycle.
    a_r8_bounded_step: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ((cnt_taken - $past(cnt_taken)) <= CNT_W'(NUM_THREADS)));
    // R8: with no mispredict in the prior cycle both counters hold.
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !(|$past(mis_vec))) |-> ($stable(cnt_taken) && $stable(cnt_ntaken)));
endmodule

// File: rtl/exec_squash_gen.sv
// Execute-stage squash and redirect generator (top).
// Per thread: recompute branch direction, arbitrate causes, register one
// squash bundle and the blocked-load acknowledge. Also counts mispredicts.
// Assumes inputs are single-cycle event strobes; sync active-low reset.
module exec_squash_gen
    import sqgen_pkg::*;
#(
    parameter int NUM_THREADS = 2,
    parameter int INST_BYTES  = 4,
    parameter bit DELAY_SLOT  = 1'b1,
    parameter int CNT_W       = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_THREADS-1:0]              br_mispred,
    input  logic [NUM_THREADS-1:0]              br_pred_taken,
    input  logic [NUM_THREADS-1:0][SEQ_W-1:0]   br_seq,
    input  logic [NUM_THREADS-1:0][ADDR_W-1:0]  br_pc,
    input  logic [NUM_THREADS-1:0][ADDR_W-1:0]  br_npc,
    input  logic [NUM_THREADS-1:0][ADDR_W-1:0]  br_nnpc,
    input  logic [NUM_THREADS-1:0]              ord_viol,
    input  logic [NUM_THREADS-1:0][SEQ_W-1:0]   ord_seq,
    input  logic [NUM_THREADS-1:0][ADDR_W-1:0]  ord_npc,
    input  logic [NUM_THREADS-1:0][ADDR_W-1:0]  ord_nnpc,
    input  logic [NUM_THREADS-1:0]              blk_valid,
    input  logic [NUM_THREADS-1:0][SEQ_W-1:0]   blk_seq,
    input  logic [NUM_THREADS-1:0][ADDR_W-1:0]  blk_pc,
    input  logic [NUM_THREADS-1:0][ADDR_W-1:0]  blk_nnpc,
    output logic [NUM_THREADS-1:0]              sq_valid,
    output logic [NUM_THREADS-1:0][SEQ_W-1:0]   sq_seq,
    output logic [NUM_THREADS-1:0][ADDR_W-1:0]  sq_pc,
    output logic [NUM_THREADS-1:0][ADDR_W-1:0]  sq_npc,
    output logic [NUM_THREADS-1:0][ADDR_W-1:0]  sq_mispc,
    output logic [NUM_THREADS-1:0]              sq_include,
    output logic [NUM_THREADS-1:0]              sq_mispredict,
    output logic [NUM_THREADS-1:0]              sq_taken,
    output logic [NUM_THREADS-1:0]              blk_ack,
    output logic [CNT_W-1:0]                    cnt_taken_bad,
    output logic [CNT_W-1:0]                    cnt_ntaken_bad
);
    bundle_t                bundle_nxt [NUM_THREADS];
    bundle_t                bundle_q   [NUM_THREADS];
    logic [NUM_THREADS-1:0] ack_nxt;
    logic [NUM_THREADS-1:0] ack_q;
    logic [NUM_THREADS-1:0] taken_calc;
    logic                   armed;

    generate
        for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
            sqgen_taken_calc #(
                .INST_BYTES (INST_BYTES),
                .DELAY_SLOT (DELAY_SLOT)
            ) u_dir (
                .pc    (br_pc[t]),
                .npc   (br_npc[t]),
                .nnpc  (br_nnpc[t]),
                .taken (taken_calc[t])
            );

            sqgen_thread_sel #(
                .DELAY_SLOT (DELAY_SLOT)
            ) u_sel (
                .br_mispred (br_mispred[t]),
                .br_taken   (taken_calc[t]),
                .br_seq     (br_seq[t]),
                .br_pc      (br_pc[t]),
                .br_npc     (br_npc[t]),
                .br_nnpc    (br_nnpc[t]),
                .ord_viol   (ord_viol[t]),
                .ord_seq    (ord_seq[t]),
                .ord_npc    (ord_npc[t]),
                .ord_nnpc   (ord_nnpc[t]),
                .blk_valid  (blk_valid[t]),
                .blk_seq    (blk_seq[t]),
                .blk_pc     (blk_pc[t]),
                .blk_nnpc   (blk_nnpc[t]),
                .nxt        (bundle_nxt[t]),
                .blk_take   (ack_nxt[t])
            );

            // Unpack the registered bundle onto the output ports.
            always_comb begin
                sq_valid[t]      = bundle_q[t].valid;
                sq_seq[t]        = bundle_q[t].seq;
                sq_pc[t]         = bundle_q[t].restart_pc;
                sq_npc[t]        = bundle_q[t].restart_npc;
                sq_mispc[t]      = bundle_q[t].mispc;
                sq_include[t]    = bundle_q[t].include_self;
                sq_mispredict[t] = bundle_q[t].mispredict;
                sq_taken[t]      = bundle_q[t].taken;
            end

            // R9: a valid bundle always traces back to an event one cycle earlier.
            a_r9_cause_seen: assert property (@(posedge clk) disable iff (!rst_n)
                (armed && sq_valid[t]) |->
                    $past(br_mispred[t] || ord_viol[t] || blk_valid[t]));
            // R1: a mispredict bundle never discards the branch itself.
            a_r1_branch_excluded: assert property (@(posedge clk) disable iff (!rst_n)
                sq_mispredict[t] |-> (sq_valid[t] && !sq_include[t]));
            // R6: an acknowledge comes with an including, non-branch bundle.
            a_r6_ack_include: assert property (@(posedge clk) disable iff (!rst_n)
                blk_ack[t] |-> (sq_valid[t] && sq_include[t] && !sq_mispredict[t]));
            // R6: the acknowledged bundle carries the blocked load's number.
            a_r6_ack_seq: assert property (@(posedge clk) disable iff (!rst_n)
                (armed && blk_ack[t]) |-> (sq_seq[t] == $past(blk_seq[t])));
            // R7: a mispredict always wins and suppresses the acknowledge.
            a_r7_branch_wins: assert property (@(posedge clk) disable iff (!rst_n)
                (armed && $past(br_mispred[t])) |-> (sq_mispredict[t] && !blk_ack[t]));
        end
    endgenerate

    // Register the bundles and acknowledges for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NUM_THREADS; t++) bundle_q[t] <= '0;
            ack_q <= '0;
            armed <= 1'b0;
        end else begin
            for (int t = 0; t < NUM_THREADS; t++) bundle_q[t] <= bundle_nxt[t];
            ack_q <= ack_nxt;
            armed <= 1'b1;
        end
    end

    // Drive the acknowledge port from its register.
    always_comb blk_ack = ack_q;

    sqgen_mispred_ctr #(
        .NUM_THREADS (NUM_THREADS),
        .CNT_W       (CNT_W)
    ) u_ctr (
        .clk            (clk),
        .rst_n          (rst_n),
        .mis_vec        (br_mispred),
        .pred_taken_vec (br_pred_taken),
        .cnt_taken      (cnt_taken_bad),
        .cnt_ntaken     (cnt_ntaken_bad)
    );
endmodule

// File: tb/sim_exec_squash_gen.sv
`timescale 1ns/1ps
module sim_exec_squash_gen;
    localparam int T = 2;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [T-1:0] br_mispred, br_pred_taken, ord_viol, blk_valid;
    logic [T-1:0][31:0] br_seq, br_pc, br_npc, br_nnpc;
    logic [T-1:0][31:0] ord_seq, ord_npc, ord_nnpc;
    logic [T-1:0][31:0] blk_seq, blk_pc, blk_nnpc;

    logic [T-1:0] a_valid, a_inc, a_mis, a_tkn, a_ack;
    logic [T-1:0][31:0] a_seq, a_pc, a_npc, a_mispc;
    logic [CW-1:0] a_ct, a_cn;
    logic [T-1:0] b_valid, b_inc, b_mis, b_tkn, b_ack;
    logic [T-1:0][31:0] b_seq, b_pc, b_npc, b_mispc;
    logic [CW-1:0] b_ct, b_cn;

    int n_cmp = 0;
    int n_bad = 0;
    int e_tw = 0;
    int e_nw = 0;

    exec_squash_gen #(.NUM_THREADS(T), .INST_BYTES(4), .DELAY_SLOT(1'b1), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .br_mispred(br_mispred), .br_pred_taken(br_pred_taken), .br_seq(br_seq),
        .br_pc(br_pc), .br_npc(br_npc), .br_nnpc(br_nnpc),
        .ord_viol(ord_viol), .ord_seq(ord_seq), .ord_npc(ord_npc), .ord_nnpc(ord_nnpc),
        .blk_valid(blk_valid), .blk_seq(blk_seq), .blk_pc(blk_pc), .blk_nnpc(blk_nnpc),
        .sq_valid(a_valid), .sq_seq(a_seq), .sq_pc(a_pc), .sq_npc(a_npc),
        .sq_mispc(a_mispc), .sq_include(a_inc), .sq_mispredict(a_mis), .sq_taken(a_tkn),
        .blk_ack(a_ack), .cnt_taken_bad(a_ct), .cnt_ntaken_bad(a_cn));

    exec_squash_gen #(.NUM_THREADS(T), .INST_BYTES(4), .DELAY_SLOT(1'b0), .CNT_W(CW)) u1 (
        .clk(clk), .rst_n(rst_n),
        .br_mispred(br_mispred), .br_pred_taken(br_pred_taken), .br_seq(br_seq),
        .br_pc(br_pc), .br_npc(br_npc), .br_nnpc(br_nnpc),
        .ord_viol(ord_viol), .ord_seq(ord_seq), .ord_npc(ord_npc), .ord_nnpc(ord_nnpc),
        .blk_valid(blk_valid), .blk_seq(blk_seq), .blk_pc(blk_pc), .blk_nnpc(blk_nnpc),
        .sq_valid(b_valid), .sq_seq(b_seq), .sq_pc(b_pc), .sq_npc(b_npc),
        .sq_mispc(b_mispc), .sq_include(b_inc), .sq_mispredict(b_mis), .sq_taken(b_tkn),
        .blk_ack(b_ack), .cnt_taken_bad(b_ct), .cnt_ntaken_bad(b_cn));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        br_mispred = '0; br_pred_taken = '0; ord_viol = '0; blk_valid = '0;
        br_seq = '0; br_pc = '0; br_npc = '0; br_nnpc = '0;
        ord_seq = '0; ord_npc = '0; ord_nnpc = '0;
        blk_seq = '0; blk_pc = '0; blk_nnpc = '0;
    endtask

    // Advance past the next rising edge and settle away from it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        clear_in();
        br_mispred = 2'b11; blk_valid = 2'b11;
        repeat (4) tick();
        rst_n = 1'b1;
        clear_in();
        chk("R10 valid", a_valid, 0);
        chk("R10 ack", a_ack, 0);
        chk("R10 fields", {a_seq[0], a_pc[1]}, 0);
        chk("R10 flags", {a_inc, a_mis, a_tkn}, 0);
        chk("R10 counters", {a_ct, a_cn, b_ct, b_cn}, 0);
    endtask

    task automatic t_mispredict();
        br_mispred[0] = 1'b1; br_pred_taken[0] = 1'b0; br_seq[0] = 32'h11;
        br_pc[0] = 32'h1000; br_npc[0] = 32'h2000; br_nnpc[0] = 32'h2004;
        tick(); e_nw++;
        clear_in();
        chk("R1 valid", a_valid, 2'b01);
        chk("R1 mispredict", a_mis[0], 1);
        chk("R1 include", a_inc[0], 0);
        chk("R1 seq", a_seq[0], 32'h11);
        chk("R1 mispc", a_mispc[0], 32'h1000);
        chk("R2 restart pc", a_pc[0], 32'h2000);
        chk("R2 restart npc", a_npc[0], 32'h2004);
        chk("R4 plain restart pc", b_pc[0], 32'h2000);
        chk("R4 plain npc zero", b_npc[0], 0);
        tick();
        chk("R9 one cycle", {a_valid, b_valid}, 0);
    endtask

    task automatic t_taken_rules();
        logic [31:0] npcs [4] = '{32'h104, 32'h108, 32'h104, 32'h300};
        logic [31:0] nnps [4] = '{32'h108, 32'h10C, 32'h200, 32'h304};
        logic exp_ds [4] = '{1'b0, 1'b0, 1'b1, 1'b1};
        logic exp_pl [4] = '{1'b0, 1'b1, 1'b0, 1'b1};
        for (int k = 0; k < 4; k++) begin
            clear_in();
            br_mispred[1] = 1'b1; br_pred_taken[1] = 1'b1; br_seq[1] = 32'h40 + k;
            br_pc[1] = 32'h100; br_npc[1] = npcs[k]; br_nnpc[1] = nnps[k];
            tick(); e_tw++;
            chk($sformatf("R3 taken case %0d", k), a_tkn[1], exp_ds[k]);
            chk($sformatf("R4 taken case %0d", k), b_tkn[1], exp_pl[k]);
        end
        clear_in();
        tick();
    endtask

    task automatic t_order();
        ord_viol[0] = 1'b1; ord_seq[0] = 32'h22; ord_npc[0] = 32'h3004; ord_nnpc[0] = 32'h3008;
        tick();
        clear_in();
        chk("R5 valid", a_valid[0], 1);
        chk("R5 seq", a_seq[0], 32'h22);
        chk("R5 restart pc", a_pc[0], 32'h3004);
        chk("R5 restart npc", a_npc[0], 32'h3008);
        chk("R5 flags inc/mis/tkn/ack", {a_inc[0], a_mis[0], a_tkn[0], a_ack[0]}, 0);
        tick();
    endtask

    task automatic t_blocked();
        blk_valid[1] = 1'b1; blk_seq[1] = 32'h33; blk_pc[1] = 32'h4000; blk_nnpc[1] = 32'h4008;
        tick();
        clear_in();
        chk("R6 seq", a_seq[1], 32'h33);
        chk("R6 restart pc", a_pc[1], 32'h4000);
        chk("R6 restart npc", a_npc[1], 32'h4008);
        chk("R6 include", a_inc[1], 1);
        chk("R6 ack", a_ack, 2'b10);
        tick();
        chk("R6 ack one cycle", {a_ack, a_valid}, 0);
    endtask

    task automatic t_priority();
        br_mispred[0] = 1'b1; br_pred_taken[0] = 1'b1; br_seq[0] = 32'h51;
        br_pc[0] = 32'h500; br_npc[0] = 32'h504; br_nnpc[0] = 32'h508;
        ord_viol = 2'b11; ord_seq[0] = 32'h52; ord_seq[1] = 32'h62; ord_npc[1] = 32'h604;
        blk_valid = 2'b11; blk_seq[0] = 32'h53; blk_seq[1] = 32'h63; blk_pc[1] = 32'h600;
        tick(); e_tw++;
        clear_in();
        chk("R7 branch wins seq", a_seq[0], 32'h51);
        chk("R7 branch wins flag", a_mis[0], 1);
        chk("R7 order wins seq", a_seq[1], 32'h62);
        chk("R7 order wins pc", a_pc[1], 32'h604);
        chk("R7 order include", a_inc[1], 0);
        chk("R7 losers not acked", a_ack, 0);
        tick();
    endtask

    task automatic t_threads();
        br_mispred[0] = 1'b1; br_seq[0] = 32'h71; br_pc[0] = 32'h700;
        br_npc[0] = 32'h704; br_nnpc[0] = 32'h708;
        blk_valid[1] = 1'b1; blk_seq[1] = 32'h81; blk_pc[1] = 32'h800;
        tick(); e_nw++;
        clear_in();
        chk("R9 both valid", a_valid, 2'b11);
        chk("R9 thread0 seq", a_seq[0], 32'h71);
        chk("R9 thread1 seq", a_seq[1], 32'h81);
        chk("R9 thread1 ack only", a_ack, 2'b10);
        br_mispred = 2'b11; br_pred_taken = 2'b11;
        tick(); e_tw += 2;
        clear_in();
        chk("R8 dual mispredict flags", a_mis, 2'b11);
        tick();
    endtask

    task automatic t_counters();
        chk("R8 taken counter", a_ct, 64'(e_tw));
        chk("R8 not-taken counter", a_cn, 64'(e_nw));
        chk("R8 plain taken counter", b_ct, 64'(e_tw));
        chk("R8 plain not-taken counter", b_cn, 64'(e_nw));
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 20000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        t_mispredict();
        t_taken_rules();
        t_order();
        t_blocked();
        t_priority();
        t_threads();
        t_counters();
        finish_run();
    end
endmodule